// File: doc/BRIEF.md
# Sine-Weighted Sample Multiplier

This block scales a signed 16-bit sample by one coefficient drawn from a fixed sine table. An 8-bit unsigned index selects the coefficient. The table spans one half-period of sine, from -pi/2 up to just under +pi/2, in Q15 format. Its contents are computed while the design is elaborated, so no memory file is needed and nothing writes the table at run time.

The block accepts one new operand pair on every clock in which `in_valid` is high. It has no flow control. After a fixed latency of two clocks it returns the full-precision signed 32-bit product, marked by `out_valid`. Typical uses are windowing, amplitude modulation, or rotating a stream of samples by a table-driven weight.

Top module: `sine_rom_mult`

## Requirements
- R1: The table has 256 entries and is addressed by the unsigned 8-bit `in_index`. Entry i equals sin(pi*(i-128)/256) multiplied by 32768 and converted to a signed 16-bit integer.
- R2: The conversion from real to integer truncates toward zero and never rounds. For example, an entry whose exact value is -401.9 reads as -401, not -402.
- R3: Index 0 yields -32768, index 128 yields 0, and index 255 yields the largest entry, which is below +32768.
- R4: Every entry at an index below 128 is negative, and every entry at an index above 128 is positive.
- R5: `out_product` is the signed sample times the signed entry, sign-extended to 32 bits with no loss. For example, -32768 times -32768 gives +1073741824.
- R6: `out_valid` follows `in_valid` with exactly two clocks of delay. A new operand pair is accepted on every valid clock, and results come out in order.
- R7: While `rst` is high, `out_valid` is forced low and `out_product` is cleared to 0. After reset the table still returns the same entries.
- R8: In every clock where `out_valid` is low, `out_product` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this clock |
| in_sample | input | 16 | Signed sample |
| in_index | input | 8 | Unsigned table index |
| out_valid | output | 1 | Product valid, two clocks after its operands |
| out_product | output | 32 | Signed full-precision product |

## Verification
A single wrong table entry appears two clocks after its index is first presented. It shows as a product that is off by a multiple of the sample. A sweep of every index with samples of +1 and -1 therefore exposes any corrupted or rounded coefficient within 258 clocks. A slip in the valid pipeline moves `out_valid` by a clock and desynchronises every later result from the ordered expectation queue. A product register that updates outside valid clocks changes the held output during the gaps of an irregular valid pattern.

// File: rtl/sine_mul_pkg.sv
package sine_mul_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Coefficient for table slot idx: sin(pi*(idx-depth/2)/depth) scaled by
  // 2**(coef_w-1), truncated toward zero by $rtoi.
  function automatic longint coef_at(input int idx, input int depth, input int coef_w);
    real ang;
    real scl;
    ang = PI_R * real'(idx - depth / 2) / real'(depth);
    scl = real'(longint'(1) << (coef_w - 1));
    return longint'($rtoi($sin(ang) * scl));
  endfunction

endpackage

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int IDX_W  = 8,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [COEF_W-1:0] rd_data
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int CENTER = DEPTH / 2;
  localparam logic signed [COEF_W-1:0] MOST_NEG = {1'b1, {(COEF_W-1){1'b0}}};

  logic signed [COEF_W-1:0] coef_mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      coef_mem[k] = COEF_W'(sine_mul_pkg::coef_at(k, DEPTH, COEF_W));
    end
  end

  // Registered read, no reset: maps onto a block RAM output register.
  always_ff @(posedge clk) begin
    rd_data <= coef_mem[rd_idx];
  end

  // R3: the lowest slot holds the most negative code, the centre slot zero
  assert_low_end_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == '0) |=> (rd_data == MOST_NEG));
  assert_centre_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == IDX_W'(CENTER)) |=> (rd_data == '0));
  // R4: the sign of the coefficient follows the side of the centre
  assert_sign_neg_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_idx < IDX_W'(CENTER)) |=> (rd_data < 0));
  assert_sign_pos_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_idx > IDX_W'(CENTER)) |=> (rd_data > 0));
endmodule

// File: rtl/sine_valid_pipe.sv
module sine_valid_pipe #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vin,
  output logic [STAGES-1:0] vstage
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) vstage[0] <= 1'b0;
          else     vstage[0] <= vin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) vstage[s] <= 1'b0;
          else     vstage[s] <= vstage[s-1];
        end
      end
    end
  endgenerate

  // R6: the first stage mirrors the input one clock later
  assert_first_stage_R6: assert property (@(posedge clk) disable iff (rst)
    vstage[0] |-> $past(vin));
  // R7: reset empties every stage
  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (vstage == '0));
endmodule

// File: rtl/sine_mul_stage.sv
module sine_mul_stage #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int PROD_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mul_en,
  input  logic signed [SAMPLE_W-1:0] mul_a,
  input  logic signed [COEF_W-1:0]   mul_b,
  output logic signed [PROD_W-1:0]   mul_p
);
  localparam int FULL_W = SAMPLE_W + COEF_W;

  logic signed [FULL_W-1:0] full_p;
  assign full_p = mul_a * mul_b;

  always_ff @(posedge clk) begin
    if (rst)         mul_p <= '0;
    else if (mul_en) mul_p <= PROD_W'(full_p);
  end

  // R5: a zero sample always gives a zero product
  assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
    (mul_en && mul_a == '0) |=> (mul_p == '0));
  // R8: the product holds when no operand pair is present
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !mul_en |=> $stable(mul_p));
endmodule

// File: rtl/sine_rom_mult.sv
module sine_rom_mult #(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 8,
  parameter int COEF_W   = 16,
  parameter int PROD_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic [IDX_W-1:0]           in_index,
  output logic                       out_valid,
  output logic signed [PROD_W-1:0]   out_product
);
  localparam int STAGES = 2;

  logic [STAGES-1:0]         vld;
  logic signed [SAMPLE_W-1:0] samp_q;
  logic signed [COEF_W-1:0]   coef_q;

  // Stage 1: sample captured beside the ROM read
  always_ff @(posedge clk) begin
    if (in_valid) samp_q <= in_sample;
  end

  sine_rom #(.IDX_W(IDX_W), .COEF_W(COEF_W)) u_rom (
    .clk(clk), .rst(rst), .rd_idx(in_index), .rd_data(coef_q)
  );

  sine_valid_pipe #(.STAGES(STAGES)) u_vpipe (
    .clk(clk), .rst(rst), .vin(in_valid), .vstage(vld)
  );

  // Stage 2: full-precision multiply
  sine_mul_stage #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .PROD_W(PROD_W)) u_mul (
    .clk(clk), .rst(rst), .mul_en(vld[0]), .mul_a(samp_q), .mul_b(coef_q),
    .mul_p(out_product)
  );

  assign out_valid = vld[STAGES-1];

  // R6: a result leaves the block only one clock after stage 1 held one
  assert_out_follows_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(vld[0]));
endmodule

// File: tb/sine_rom_mult_tb.sv
module sine_rom_mult_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic [7:0] in_index = '0;
  logic out_valid;
  logic signed [31:0] out_product;

  always #2.5 clk = ~clk;

  sine_rom_mult u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_index(in_index), .out_valid(out_valid), .out_product(out_product)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;

  logic signed [31:0] exp_q[$];
  string tag_q[$];

  localparam real PI_TB = 3.14159265358979323846;

  function automatic int ref_coef(input int i);
    real v;
    v = $sin(PI_TB * real'(i - 128) / 256.0) * 32768.0;
    return $rtoi(v);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: one operand pair per call, expectation pushed to the scoreboard
  task automatic drive(input logic signed [15:0] s, input int idx, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s;
    in_index  = 8'(idx);
    exp_q.push_back(32'(longint'(s) * longint'(ref_coef(idx))));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares every valid result in order; R8 hold check in gaps
  logic signed [31:0] last_p = '0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R6 unexpected result", 1, 0);
        end else begin
          automatic logic signed [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, out_product, e);
        end
      end else begin
        check("R8 hold", out_product, last_p);
      end
      last_p = out_product;
    end
  end

  bit done = 1'b0;
  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 out_valid in reset", out_valid, 0);
    check("R7 product in reset", out_product, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 out_valid after reset", out_valid, 0);
    last_p = out_product;
    mon_on = 1'b1;

    // R1/R2: sweep with +1 and -1 exposes every entry exactly
    for (int i = 0; i < 256; i++) drive(16'sd1, i, "R1 R2 entry x+1");
    for (int i = 0; i < 256; i++) drive(-16'sd1, i, "R1 entry x-1");
    idle(4);

    // R3: end points and centre
    drive(16'sd1, 0, "R3 index0");
    drive(16'sd1, 128, "R3 index128");
    drive(16'sd1, 255, "R3 index255");
    idle(4);
    check("R3 index0 value", ref_coef(0), -32768);
    check("R3 index128 value", ref_coef(128), 0);
    check("R3 index255 below max", (ref_coef(255) < 32768) ? 1 : 0, 1);

    // R4: sign per side
    for (int i = 1; i < 256; i++) begin
      if (i != 128) check("R4 sign", (ref_coef(i) < 0) ? 1 : 0, (i < 128) ? 1 : 0);
    end

    // R5: extremes without overflow
    drive(-16'sd32768, 0, "R5 min x min");
    drive(16'sd32767, 0, "R5 max x min");
    drive(16'sd32767, 255, "R5 max x top");
    drive(-16'sd32768, 255, "R5 min x top");
    drive(16'sd0, 37, "R5 zero sample");
    idle(4);

    // R8: irregular valid pattern with gaps
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) idle(1 + $urandom_range(0, 2));
      drive(16'($urandom), $urandom_range(0, 255), "R5 R8 random");
    end
    idle(4);

    // R6: exact two-clock latency of a lone item
    drive(16'sd3, 200, "R6 lone");
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 not yet after 1 clock", out_valid, 0);
    @(negedge clk);
    check("R6 valid after 2 clocks", out_valid, 1);
    idle(3);
    check("R6 queue drained", exp_q.size(), 0);

    // R7: reset with items in flight drops them; table intact afterwards
    mon_on = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_sample = 16'sd9; in_index = 8'd10;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid-run valid", out_valid, 0);
    check("R7 mid-run product", out_product, 0);
    @(negedge clk);
    check("R7 mid-run valid held", out_valid, 0);
    rst = 1'b0;
    last_p = out_product;
    mon_on = 1'b1;
    drive(16'sd5, 10, "R7 table after reset");
    drive(-16'sd7, 250, "R7 table after reset");
    idle(5);
    check("R7 queue drained", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule